// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave holds stuck by keeping the data line low. It sits beside the master engine of an I2C controller. It starts in one of two ways. The first is an explicit request pulse, for example when a transfer did not complete in time. The second is the bus-busy indication staying asserted for longer than the transfer timeout.

Once started, the block runs a fixed clear recipe. It raises the not-acknowledge control so the master will not acknowledge the slave. It then drives SCL through nine slow manual pulses, each of which goes low first and then high. After the pulses it asks the master engine for a STOP condition. When the bus has had one phase time to settle, the block pulses a re-initialise strobe to the controller. If bus-busy has cleared by then, it reports success. If the bus is still busy, it runs the recipe again. After a limited number of retries it reports failure.

Phase lengths are expressed in microseconds and scaled by a clocks-per-microsecond parameter. The defaults are a 20 us phase and a one-second timeout.

Top module: `bus_clear_seq`

## Requirements
- R1: After reset and whenever the block is idle, scl_low_o, nack_o, stop_o, reinit_o, done_o and fail_o are all 0.
- R2: A req_i pulse sampled while idle starts recovery, and nack_o is 1 in the very next cycle.
- R3: Recovery starts by itself once busy_i has been 1 on TIMEOUT_US*CLKS_PER_US consecutive clock edges. A shorter busy stretch starts nothing, and the count restarts from zero whenever busy_i drops.
- R4: nack_o rises one cycle before the first SCL low phase. It stays 1 through every pulse and through the STOP cycle, so scl_low_o is never 1 while nack_o is 0.
- R5: Each attempt produces exactly NUM_PULSES (default 9) SCL pulses on scl_low_o, where 1 means drive SCL low. Each pulse is a low phase followed by a high (released) phase.
- R6: Every low phase and every high phase lasts exactly PHASE_US*CLKS_PER_US cycles.
- R7: stop_o is a single-cycle pulse in the cycle right after the last high phase ends. SCL is released during it, and nack_o falls in the following cycle.
- R8: reinit_o pulses PHASE_US*CLKS_PER_US+1 cycles after stop_o. If busy_i is 0 in that cycle, done_o pulses in the same cycle.
- R9: If busy_i is still 1 in the reinit_o cycle, the recipe restarts, up to MAX_RETRY (default 2) times. On the final attempt fail_o pulses instead of done_o, so one failing run yields (MAX_RETRY+1)*NUM_PULSES pulses and never a done_o.
- R10: The retry count only covers consecutive attempts. It clears after any done_o or fail_o, so a later stuck bus again gets the full MAX_RETRY+1 attempts.
- R11: While recovery is running, req_i and the busy timeout have no effect. The recovery in progress is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Explicit recovery request pulse |
| busy_i | input | 1 | Bus-busy indication from the controller |
| scl_low_o | output | 1 | 1 = drive SCL low, 0 = release SCL |
| nack_o | output | 1 | Not-acknowledge control to the master engine |
| stop_o | output | 1 | STOP request pulse to the master engine |
| reinit_o | output | 1 | Controller re-initialise strobe |
| done_o | output | 1 | Recovery succeeded (pulse) |
| fail_o | output | 1 | Recovery failed after all retries (pulse) |

## Verification
Internal faults show up on the ports fairly quickly, though not all at the same speed.

- A wrong phase counter shows on scl_low_o within the first pulse, as a low or high run that is not exactly one phase long.
- A wrong pulse counter shows at the STOP cycle, as a pulse total other than nine per attempt.
- A retry counter that does not clear, or that wraps, only becomes visible one or more whole recovery runs later. It appears as a wrong number of attempts before fail_o, or as done_o and fail_o being swapped.
- A busy-watch counter that is off by one moves the start of nack_o by a cycle away from the exact timeout edge. A counter that is not cleared turns a short busy glitch into a recovery.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_NACK, ST_LOW, ST_HIGH, ST_STOP, ST_SETTLE, ST_CHECK
  } bcs_state_e;
endpackage

// File: rtl/bcs_phase_timer.sv
`timescale 1ns/1ps
module bcs_phase_timer #(
  parameter int CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_busy_watch.sv
`timescale 1ns/1ps
module bcs_busy_watch #(
  parameter int CYC = 100000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  output logic expire_o
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  // fires on the CYC-th consecutive edge with busy high
  assign expire_o = en_i && busy_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!en_i || !busy_i || expire_o)  cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_fsm.sv
`timescale 1ns/1ps
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int NUM_PULSES = 9,
  parameter int MAX_RETRY  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       expire_i,
  input  logic       tick_i,
  input  logic       busy_i,
  output bcs_state_e state_o,
  output logic       scl_low_o,
  output logic       nack_o,
  output logic       stop_o,
  output logic       reinit_o,
  output logic       done_o,
  output logic       fail_o
);
  localparam int PW = $clog2(NUM_PULSES + 1);
  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [PW-1:0] LAST_PULSE = PW'(NUM_PULSES - 1);
  localparam logic [RW-1:0] RETRY_MAX  = RW'(MAX_RETRY);

  bcs_state_e  state_q, state_d;
  logic [PW-1:0] pulse_q;
  logic [RW-1:0] retry_q;
  logic          out_of_retries;

  assign out_of_retries = (retry_q == RETRY_MAX);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i || expire_i) state_d = ST_NACK;
      ST_NACK:   state_d = ST_LOW;
      ST_LOW:    if (tick_i) state_d = ST_HIGH;
      ST_HIGH:   if (tick_i) state_d = (pulse_q == LAST_PULSE) ? ST_STOP : ST_LOW;
      ST_STOP:   state_d = ST_SETTLE;
      ST_SETTLE: if (tick_i) state_d = ST_CHECK;
      ST_CHECK:  state_d = (busy_i && !out_of_retries) ? ST_NACK : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_NACK)                 pulse_q <= '0;
      else if (state_q == ST_HIGH && tick_i)  pulse_q <= pulse_q + 1'b1;
      if (state_q == ST_CHECK)
        retry_q <= (busy_i && !out_of_retries) ? retry_q + 1'b1 : '0;
    end
  end

  assign state_o   = state_q;
  assign scl_low_o = (state_q == ST_LOW);
  assign nack_o    = (state_q == ST_NACK) || (state_q == ST_LOW) ||
                     (state_q == ST_HIGH) || (state_q == ST_STOP);
  assign stop_o    = (state_q == ST_STOP);
  assign reinit_o  = (state_q == ST_CHECK);
  assign done_o    = (state_q == ST_CHECK) && !busy_i;
  assign fail_o    = (state_q == ST_CHECK) && busy_i && out_of_retries;
endmodule

// File: rtl/bus_clear_seq.sv
`timescale 1ns/1ps
module bus_clear_seq
  import bcs_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int PHASE_US    = 20,
  parameter int TIMEOUT_US  = 1000000,
  parameter int NUM_PULSES  = 9,
  parameter int MAX_RETRY   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic scl_low_o,
  output logic nack_o,
  output logic stop_o,
  output logic reinit_o,
  output logic done_o,
  output logic fail_o
);
  localparam int PHASE_CYC   = CLKS_PER_US * PHASE_US;
  localparam int TIMEOUT_CYC = CLKS_PER_US * TIMEOUT_US;

  bcs_state_e state;
  logic       tick, expire, timer_run, idle;

  assign idle      = (state == ST_IDLE);
  assign timer_run = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_SETTLE);

  bcs_phase_timer #(.CYC(PHASE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (timer_run),
    .tick_o (tick)
  );

  bcs_busy_watch #(.CYC(TIMEOUT_CYC)) u_watch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (idle),
    .busy_i   (busy_i),
    .expire_o (expire)
  );

  bcs_fsm #(.NUM_PULSES(NUM_PULSES), .MAX_RETRY(MAX_RETRY)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .expire_i  (expire),
    .tick_i    (tick),
    .busy_i    (busy_i),
    .state_o   (state),
    .scl_low_o (scl_low_o),
    .nack_o    (nack_o),
    .stop_o    (stop_o),
    .reinit_o  (reinit_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
  );
endmodule

// File: rtl/bus_clear_seq_chk.sv
`timescale 1ns/1ps
module bus_clear_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic busy_i,
  input logic idle_i,
  input logic scl_low_o,
  input logic nack_o,
  input logic stop_o,
  input logic reinit_o,
  input logic done_o,
  input logic fail_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !(scl_low_o || nack_o || stop_o || reinit_o || done_o || fail_o));

  p_req_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && req_i) |=> nack_o);

  p_scl_needs_nack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_low_o |-> nack_o);

  p_stop_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (nack_o && !scl_low_o) ##1 (!stop_o && !nack_o));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_i && reinit_o));

  p_fail_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (busy_i && reinit_o && !done_o));

  p_busy_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_low_o && req_i) |=> !idle_i);
endmodule

bind bus_clear_seq bus_clear_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .busy_i    (busy_i),
  .idle_i    (idle),
  .scl_low_o (scl_low_o),
  .nack_o    (nack_o),
  .stop_o    (stop_o),
  .reinit_o  (reinit_o),
  .done_o    (done_o),
  .fail_o    (fail_o)
);

// File: tb/sim_bus_clear_seq.sv
`timescale 1ns/1ps
module sim_bus_clear_seq;
  localparam int CPU = 1;
  localparam int PH_US = 20;
  localparam int TO_US = 50;
  localparam int NP = 9;
  localparam int MR = 2;
  localparam int PH = CPU * PH_US;
  localparam int TO = CPU * TO_US;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic busy_i = 1'b0;
  logic scl_low_o, nack_o, stop_o, reinit_o, done_o, fail_o;

  int checks = 0;
  int errors = 0;

  int cyc = 0, n_pulse = 0, n_stop = 0, n_done = 0, n_fail = 0, n_reinit = 0;
  int n_nack = 0, bad_lo = 0, bad_hi = 0, bad_nack = 0;
  int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0, cyc_stop = 0, cyc_done = 0;
  bit in_hi = 0, p_scl = 0, p_nack = 0;

  always #2 clk_i = ~clk_i;

  bus_clear_seq #(
    .CLKS_PER_US(CPU), .PHASE_US(PH_US), .TIMEOUT_US(TO_US),
    .NUM_PULSES(NP), .MAX_RETRY(MR)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_i(busy_i),
    .scl_low_o(scl_low_o), .nack_o(nack_o), .stop_o(stop_o),
    .reinit_o(reinit_o), .done_o(done_o), .fail_o(fail_o)
  );

  // port monitor, sampled at the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (scl_low_o && !p_scl) begin
        n_pulse++;
        lo_run = 1;
        if (in_hi) begin
          last_hi = hi_run;
          if (hi_run != PH) bad_hi++;
          in_hi = 0;
        end
      end else if (scl_low_o) begin
        lo_run++;
      end
      if (!scl_low_o && p_scl) begin
        last_lo = lo_run;
        if (lo_run != PH) bad_lo++;
        in_hi = 1;
        hi_run = 1;
      end else if (in_hi && !scl_low_o && !stop_o) begin
        hi_run++;
      end
      if (stop_o) begin
        n_stop++;
        cyc_stop = cyc;
        if (in_hi) begin
          last_hi = hi_run;
          if (hi_run != PH) bad_hi++;
          in_hi = 0;
        end
      end
      if (done_o) begin n_done++; cyc_done = cyc; end
      if (fail_o) n_fail++;
      if (reinit_o) n_reinit++;
      if (nack_o && !p_nack) n_nack++;
      if (scl_low_o && !nack_o) bad_nack++;
      p_scl = scl_low_o;
      p_nack = nack_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wait_end(input int base, input int limit);
    int k = 0;
    while ((n_done + n_fail) == base && k < limit) begin
      step();
      k++;
    end
    if (k >= limit) chk("wait_end timeout", k, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) step();
    chk("R1 reset outputs", {scl_low_o, nack_o, stop_o, reinit_o, done_o, fail_o}, 0);
    rst_ni = 1'b1;
    repeat (3) step();
    chk("R1 idle outputs", {scl_low_o, nack_o, stop_o, reinit_o, done_o, fail_o}, 0);
  endtask

  task automatic t_request();
    int bp = n_pulse, bs = n_stop, bd = n_done, bf = n_fail, br = n_reinit;
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    chk("R2 nack next cycle", nack_o, 1);
    chk("R4 nack before scl low", scl_low_o, 0);
    wait_end(bd + bf, 2000);
    chk("R5 pulse count", n_pulse - bp, NP);
    chk("R6 low phase length", last_lo, PH);
    chk("R6 high phase length", last_hi, PH);
    chk("R6 bad phases", bad_lo + bad_hi, 0);
    chk("R7 stop count", n_stop - bs, 1);
    chk("R8 done count", n_done - bd, 1);
    chk("R8 reinit count", n_reinit - br, 1);
    chk("R8 stop to done cycles", cyc_done - cyc_stop, PH + 1);
    chk("R9 no fail", n_fail - bf, 0);
    chk("R4 scl low without nack", bad_nack, 0);
    step();
    chk("R1 idle after done", {scl_low_o, nack_o, stop_o, reinit_o}, 0);
  endtask

  task automatic t_glitch();
    int bn = n_nack;
    busy_i = 1'b1;
    repeat (TO - 1) step();
    busy_i = 1'b0;
    repeat (5) step();
    busy_i = 1'b1;
    repeat (TO - 1) step();
    busy_i = 1'b0;
    repeat (20) step();
    chk("R3 short busy ignored", n_nack - bn, 0);
  endtask

  task automatic t_stuck(input string tag);
    int bp = n_pulse, bs = n_stop, bd = n_done, bf = n_fail, br = n_reinit;
    int n = 0;
    busy_i = 1'b1;
    while (!nack_o && n < 200) begin
      step();
      n++;
    end
    chk({tag, " R3 timeout edge"}, n, TO);
    wait_end(bd + bf, 5000);
    step();
    busy_i = 1'b0;
    chk({tag, " R9 pulses"}, n_pulse - bp, (MR + 1) * NP);
    chk({tag, " R9 stops"}, n_stop - bs, MR + 1);
    chk({tag, " R9 reinits"}, n_reinit - br, MR + 1);
    chk({tag, " R9 fail"}, n_fail - bf, 1);
    chk({tag, " R9 no done"}, n_done - bd, 0);
    repeat (5) step();
  endtask

  task automatic t_mid_clear();
    int bp = n_pulse, bs = n_stop, bd = n_done, bf = n_fail, br = n_reinit;
    int k = 0;
    busy_i = 1'b1;
    while (n_reinit == br && k < 3000) begin
      step();
      k++;
    end
    step();
    busy_i = 1'b0;
    wait_end(bd + bf, 2000);
    chk("R9 retry then done pulses", n_pulse - bp, 2 * NP);
    chk("R9 retry then done stops", n_stop - bs, 2);
    chk("R8 retry then done", n_done - bd, 1);
    chk("R9 retry then no fail", n_fail - bf, 0);
    repeat (5) step();
  endtask

  task automatic t_ignore();
    int bn = n_nack, bp = n_pulse, bd = n_done, bf = n_fail;
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    repeat (100) step();
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    busy_i = 1'b1;
    repeat (TO + 20) step();
    busy_i = 1'b0;
    wait_end(bd + bf, 2000);
    chk("R11 pulses unchanged", n_pulse - bp, NP);
    chk("R11 single start", n_nack - bn, 1);
    chk("R11 done once", n_done - bd, 1);
    repeat (30) step();
    chk("R11 no later start", n_nack - bn, 1);
  endtask

  initial begin
    t_reset();
    t_request();
    t_glitch();
    t_stuck("first");
    t_mid_clear();
    t_stuck("R10 after done");
    t_ignore();
    chk("R4 scl low without nack overall", bad_nack, 0);
    chk("R6 bad phases overall", bad_lo + bad_hi, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule